// File: doc/BRIEF.md
# Piecewise Polynomial Logistic Activation Unit

This unit computes an approximation of the logistic sigmoid 1/(1+e^-x) for neural-network activation in fixed point. A signed 16-bit input in Q4.12 format (4 integer bits including sign, 12 fractional bits, so 1.0 is code 4096) is classified into one of six regions. There are two constant tails, two linear segments and two quadratic segments that meet at zero. The polynomial for the selected region is evaluated with truncating fixed-point multiplies, and the result is registered once.

A single evaluation path serves every region. Each region supplies a triple (a, b, c) to a Horner evaluator that computes ((a·x)+b)·x + c. Linear segments use a = 0, and the tails use a = b = 0. The boundaries and coefficients are least-squares constants that need not be powers of two. They are converted to Q4.12 at elaboration by rounding value·4096 to the nearest integer. A parameter selects one of two fitted sets: one tuned for the lowest mean error and one tuned for the lowest peak error.

Top module: `sigm_act`

## Requirements
- R1: The result for an input sampled on a rising clock edge appears on `y_o` directly after that edge, so the latency is exactly one clock. There is no iteration.
- R2: With the mean set, any input below −22282 (−5.44) gives 0. For example, −32768 and −22283 both give 0.
- R3: With the mean set, any input at or above +22282 (+5.44) gives 4096 (1.0).
- R4: The linear segments are y = trunc(58·x) + 314 for −22282 ≤ x < −13312, and y = trunc(58·x) + 3782 for 13312 ≤ x < 22282. This gives −22282 → −2, −13313 → 125, 13312 → 3970 and 22281 → 4097.
- R5: The quadratic segments use a = 165, b = 1116, c = 2057 for −13312 ≤ x < 0, and a = −165, b = 1116, c = 2039 for 0 ≤ x < 13312. A boundary value belongs to the region on its right, so 0 → 2039, −1 → 2056, −13312 → 172 and 13311 → 3923.
- R6: Every product is reduced by discarding low-order bits, which truncates toward minus infinity with no rounding. The intermediate a·x+b keeps 4 extra fractional bits, and the final product is reduced to Q4.12.
- R7: Across all 65536 input codes with the mean set, no absolute error against the true sigmoid exceeds 0.008. The mean absolute error does not exceed 1.7e-3.
- R8: With COEF_SET = 1 (the peak set), the outer boundaries are ±21258 and the inner boundaries are ±13271. This gives 21258 → 4096, 21257 → 4089, −21258 → 6 and −21259 → 0. Over all codes the peak error is at most 0.008 and the mean error is at most 2.0e-3.
- R9: While `rst_ni` is low, `y_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the input is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the output |
| x_i | input | 16 | Signed Q4.12 operand |
| y_o | output | 16 | Signed Q4.12 sigmoid approximation, registered |

## Verification
Every result appears on `y_o` one clock after its operand is sampled. The bench drives `x_i` on a falling edge and reads `y_o` at the following falling edge, which is half a period after the registering edge. The directed boundary checks and the full sweep both use this two-falling-edge step, so each reading matches exactly the operand that produced it. The assertions compare the output one cycle after the input with `|=>`, which uses the same latency.

// File: rtl/sigm_pkg.sv
package sigm_pkg;

    localparam int SIG_W    = 16;
    localparam int SIG_FRAC = 12;
    localparam int SIG_GRD  = 4;

    typedef enum logic [2:0] {
        RG_ZERO = 3'd0,
        RG_LINN = 3'd1,
        RG_QNEG = 3'd2,
        RG_QPOS = 3'd3,
        RG_LINP = 3'd4,
        RG_ONE  = 3'd5
    } region_t;

endpackage

// File: rtl/sigm_coef.sv
module sigm_coef
    import sigm_pkg::*;
#(
    parameter int W        = SIG_W,
    parameter int FRAC     = SIG_FRAC,
    parameter int COEF_SET = 0
) (
    input  region_t             region_i,
    output logic signed [W-1:0] a_o,
    output logic signed [W-1:0] b_o,
    output logic signed [W-1:0] c_o,
    output logic signed [W-1:0] outer_o,
    output logic signed [W-1:0] inner_o
);

    localparam real SCALE = 2.0 ** FRAC;

    logic signed [W-1:0] k_outer, k_inner, k_lin_m, k_lin_n, k_lin_p;
    logic signed [W-1:0] k_qn_a, k_qn_b, k_qn_c, k_qp_a, k_qp_b, k_qp_c, k_one;

    assign k_one = W'(int'(1.0 * SCALE));

    generate
        if (COEF_SET == 0) begin : g_mean
            assign k_outer = W'(int'(5.44 * SCALE));
            assign k_inner = W'(int'(3.25 * SCALE));
            assign k_lin_m = W'(int'(0.014117 * SCALE));
            assign k_lin_n = W'(int'(0.076735 * SCALE));
            assign k_lin_p = W'(int'(0.923265 * SCALE));
            assign k_qn_a  = W'(int'(0.040384 * SCALE));
            assign k_qn_b  = W'(int'(0.272505 * SCALE));
            assign k_qn_c  = W'(int'(0.502208 * SCALE));
            assign k_qp_a  = W'(int'(-0.040394 * SCALE));
            assign k_qp_b  = W'(int'(0.272543 * SCALE));
            assign k_qp_c  = W'(int'(0.497762 * SCALE));
        end else begin : g_peak
            assign k_outer = W'(int'(5.19 * SCALE));
            assign k_inner = W'(int'(3.24 * SCALE));
            assign k_lin_m = W'(int'(0.015656 * SCALE));
            assign k_lin_n = W'(int'(0.082845 * SCALE));
            assign k_lin_p = W'(int'(0.917155 * SCALE));
            assign k_qn_a  = W'(int'(0.040434 * SCALE));
            assign k_qn_b  = W'(int'(0.272634 * SCALE));
            assign k_qn_c  = W'(int'(0.502260 * SCALE));
            assign k_qp_a  = W'(int'(-0.040444 * SCALE));
            assign k_qp_b  = W'(int'(0.272674 * SCALE));
            assign k_qp_c  = W'(int'(0.497709 * SCALE));
        end
    endgenerate

    assign outer_o = k_outer;
    assign inner_o = k_inner;

    // Tails and linear segments reuse the Horner path with zeroed high terms.
    always_comb begin
        a_o = '0;
        b_o = '0;
        c_o = '0;
        unique case (region_i)
            RG_ZERO: c_o = '0;
            RG_LINN: begin b_o = k_lin_m; c_o = k_lin_n; end
            RG_QNEG: begin a_o = k_qn_a; b_o = k_qn_b; c_o = k_qn_c; end
            RG_QPOS: begin a_o = k_qp_a; b_o = k_qp_b; c_o = k_qp_c; end
            RG_LINP: begin b_o = k_lin_m; c_o = k_lin_p; end
            RG_ONE:  c_o = k_one;
            default: c_o = '0;
        endcase
    end

endmodule

// File: rtl/sigm_region.sv
module sigm_region
    import sigm_pkg::*;
#(
    parameter int W = SIG_W
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] outer_i,
    input  logic signed [W-1:0] inner_i,
    output region_t             region_o
);

    logic signed [W-1:0] neg_outer, neg_inner;

    assign neg_outer = -outer_i;
    assign neg_inner = -inner_i;

    // A value equal to a boundary falls into the region on its right.
    always_comb begin
        if (x_i < neg_outer)       region_o = RG_ZERO;
        else if (x_i < neg_inner)  region_o = RG_LINN;
        else if (x_i < 0)          region_o = RG_QNEG;
        else if (x_i < inner_i)    region_o = RG_QPOS;
        else if (x_i < outer_i)    region_o = RG_LINP;
        else                       region_o = RG_ONE;
    end

endmodule

// File: rtl/sigm_horner.sv
module sigm_horner
    import sigm_pkg::*;
#(
    parameter int W    = SIG_W,
    parameter int FRAC = SIG_FRAC,
    parameter int GRD  = SIG_GRD
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic signed [W-1:0] c_i,
    output logic signed [W-1:0] y_o
);

    localparam int PW1 = 2 * W;
    localparam int TW  = W + GRD;
    localparam int PW2 = W + TW;

    logic signed [PW1-1:0] prod_ax;
    logic signed [TW-1:0]  inner_t;
    logic signed [PW2-1:0] prod_tx;
    logic signed [W-1:0]   scaled;

    always_comb begin
        prod_ax = PW1'(a_i) * PW1'(x_i);
        // Keep GRD extra fraction bits; dropped bits truncate toward minus infinity.
        inner_t = $signed(prod_ax[W+FRAC-1:FRAC-GRD]) + (TW'(b_i) <<< GRD);
        prod_tx = PW2'(inner_t) * PW2'(x_i);
        scaled  = $signed(prod_tx[W+FRAC+GRD-1:FRAC+GRD]);
        y_o     = scaled + c_i;
    end

endmodule

// File: rtl/sigm_act.sv
module sigm_act
    import sigm_pkg::*;
#(
    parameter int W        = SIG_W,
    parameter int FRAC     = SIG_FRAC,
    parameter int GRD      = SIG_GRD,
    parameter int COEF_SET = 0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic signed [W-1:0] x_i,
    output logic signed [W-1:0] y_o
);

    localparam logic signed [W-1:0] ONE = W'(1 << FRAC);

    typedef struct packed {
        logic signed [W-1:0] y;
    } state_t;

    region_t             region;
    logic signed [W-1:0] coef_a, coef_b, coef_c, bnd_outer, bnd_inner, y_calc;
    state_t              st_d, st_q;

    sigm_coef #(.W(W), .FRAC(FRAC), .COEF_SET(COEF_SET)) coef_i (
        .region_i (region),
        .a_o      (coef_a),
        .b_o      (coef_b),
        .c_o      (coef_c),
        .outer_o  (bnd_outer),
        .inner_o  (bnd_inner)
    );

    sigm_region #(.W(W)) region_i (
        .x_i      (x_i),
        .outer_i  (bnd_outer),
        .inner_i  (bnd_inner),
        .region_o (region)
    );

    sigm_horner #(.W(W), .FRAC(FRAC), .GRD(GRD)) horner_i (
        .x_i (x_i),
        .a_i (coef_a),
        .b_i (coef_b),
        .c_i (coef_c),
        .y_o (y_calc)
    );

    always_comb begin
        st_d   = st_q;
        st_d.y = y_calc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign y_o = st_q.y;

    // R2
    low_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i < -bnd_outer) |=> (y_o == '0));

    // R3
    high_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i >= bnd_outer) |=> (y_o == ONE));

    // R4
    lin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i >= -bnd_outer && x_i < -bnd_inner) |=> (y_o >= -W'(8) && y_o < (ONE >>> 3)));

    // R5
    quad_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i >= -bnd_inner && x_i < bnd_inner) |=> (y_o > '0 && y_o < ONE));

    // R5
    zero_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_i == '0) |=> (y_o > (ONE >>> 1) - W'(64) && y_o < (ONE >>> 1) + W'(64)));

endmodule

// File: tb/sigm_act_tb_top.sv
module sigm_act_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 180000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] x = '0;
    logic signed [15:0] y_mean, y_peak;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigm_act #(.COEF_SET(0)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .x_i (x), .y_o (y_mean)
    );

    sigm_act #(.COEF_SET(1)) dut_pk_i (
        .clk_i (clk), .rst_ni (rst_n), .x_i (x), .y_o (y_peak)
    );

    function automatic real sig_ref(input real v);
        return 1.0 / (1.0 + $exp(-v));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on a falling edge, read after the next rising edge has registered it.
    task automatic apply(input int v);
        @(negedge clk);
        x = 16'(v);
        @(negedge clk);
    endtask

    task automatic t_exact(input int v, input int exp_m, input string req);
        apply(v);
        chk(y_mean == 16'(exp_m), req, int'(y_mean), exp_m);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        x = 16'sd13000;
        repeat (3) @(negedge clk);
        chk(y_mean == 0, "R9", int'(y_mean), 0);
        chk(y_peak == 0, "R9", int'(y_peak), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        // R1: result for a new operand is present one clock after sampling
        @(negedge clk); x = -16'sd32768;
        @(negedge clk); x = 16'sd32767;
        chk(y_mean == 0, "R1", int'(y_mean), 0);
        @(negedge clk);
        chk(y_mean == 16'sd4096, "R1", int'(y_mean), 4096);
    endtask

    task automatic t_tails();
        t_exact(-32768, 0, "R2");
        t_exact(-22283, 0, "R2");
        t_exact(22282, 4096, "R3");
        t_exact(32767, 4096, "R3");
    endtask

    task automatic t_linear();
        t_exact(-22282, -2, "R4");
        t_exact(-13313, 125, "R4");
        t_exact(13312, 3970, "R4");
        t_exact(22281, 4097, "R4");
    endtask

    task automatic t_quad();
        t_exact(0, 2039, "R5");
        t_exact(-1, 2056, "R5");
        t_exact(-13312, 172, "R5");
        t_exact(13311, 3923, "R6");
    endtask

    task automatic t_peak_set();
        apply(21258);  chk(y_peak == 16'sd4096, "R8", int'(y_peak), 4096);
        apply(21257);  chk(y_peak == 16'sd4089, "R8", int'(y_peak), 4089);
        apply(-21258); chk(y_peak == 16'sd6, "R8", int'(y_peak), 6);
        apply(-21259); chk(y_peak == 0, "R8", int'(y_peak), 0);
    endtask

    task automatic t_sweep();
        real sum_m = 0.0, sum_p = 0.0, max_m = 0.0, max_p = 0.0;
        for (int i = -32768; i < 32768; i++) begin
            real xv, ref_v, e_m, e_p;
            apply(i);
            xv    = real'(i) / 4096.0;
            ref_v = sig_ref(xv);
            e_m   = real'(y_mean) / 4096.0 - ref_v;
            e_p   = real'(y_peak) / 4096.0 - ref_v;
            if (e_m < 0.0) e_m = -e_m;
            if (e_p < 0.0) e_p = -e_p;
            sum_m += e_m;
            sum_p += e_p;
            if (e_m > max_m) max_m = e_m;
            if (e_p > max_p) max_p = e_p;
            if (e_m > 0.008)
                chk(1'b0, "R7", int'(y_mean), int'(ref_v * 4096.0));
            if (e_p > 0.008)
                chk(1'b0, "R8", int'(y_peak), int'(ref_v * 4096.0));
        end
        n_chk += 2;
        $display("mean set: peak %f mean %f; peak set: peak %f mean %f",
                 max_m, sum_m / 65536.0, max_p, sum_p / 65536.0);
        chk(sum_m / 65536.0 <= 1.7e-3, "R7",
            int'(sum_m / 65536.0 * 1.0e6), 1700);
        chk(sum_p / 65536.0 <= 2.0e-3, "R8",
            int'(sum_p / 65536.0 * 1.0e6), 2000);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYC, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_tails();
        t_linear();
        t_quad();
        t_peak_set();
        t_sweep();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule